// File: doc/BRIEF.md
# Flash program/erase timing sequencer

This block drives the control strobes of a nonvolatile memory array for two operations: programming selected bytes of one row, and erasing the whole array. A host hands it one command at a time over a request/acknowledge port. The block then steps the external programming supply request, the program select, the erase select, the high-voltage enable and the write-data strobe through a fixed order. Every interval in that order is a whole number of clock cycles. Each one is derived at elaboration from a clock-frequency parameter and a time in nanoseconds, and rounded up.

The block also tracks wear between erases. It keeps a small saturating count of how often each byte address has been programmed. For each row it keeps the total write-strobe time already spent. A program command that would write an address a third time, or push a row past its time budget, is refused with an error flag. A refused command leaves every strobe low. A program command with an empty byte mask is refused the same way. An accepted erase clears all wear records.

Top module: `nvm_pe_sequencer`

## Requirements
- R1: During and right after reset, every strobe, `busy`, `cmd_ack` and `cmd_err` are low.
- R2: `supply_req` rises in the cycle after acceptance. A select rises ceil(T_SUPPLY_SU_NS·f) cycles later. `supply_req` falls ceil(T_SUPPLY_HOLD_NS·f) cycles after the select falls. Every interval is ceil(ns·CLK_KHZ/10^6) cycles, with a minimum of 1.
- R3: In a program, `hv_en` rises ceil(5 µs·f) cycles after `prog_sel` rises. The first `wr_stb` comes ceil(10 µs·f) cycles after that. `hv_en` falls together with the last `wr_stb`, and `prog_sel` falls ceil(5 µs·f) cycles later. The two selects are never high together.
- R4: Each write pulse lasts ceil(20 µs·f) cycles, which is never more than 40 µs. Pulses are separated by one cycle with `hv_en` still high. Bytes go out lowest mask bit first. The address is {row, byte index}, and the data is `cmd_data[8i+7:8i]` for byte index i.
- R5: In an erase (`cmd_erase`=1), `erase_sel` rises. After ceil(5 µs·f) cycles, `hv_en` stays high for ceil(T_ERASE_NS·f) cycles. `erase_sel` falls ceil(100 µs·f) cycles after `hv_en` falls.
- R6: After `supply_req` falls, ceil(1 µs·f) recovery cycles pass with `busy` high and all strobes low. `busy` is high from the cycle after acceptance to the end of recovery. A request made while busy is not acknowledged.
- R7: A request seen while idle is answered by a one-cycle `cmd_ack` in the next cycle. `cmd_err` is high only together with `cmd_ack`, and only when the command is refused.
- R8: A program command that includes an address already programmed twice since the last erase is refused.
- R9: A program command is refused when the row's used write time plus (mask bits set × write pulse cycles) would exceed ceil(ROW_BUDGET_NS·f).
- R10: A refused command raises no strobe, leaves `busy` low, and changes no wear record.
- R11: A program command with an all-zero byte mask is refused.
- R12: An accepted erase clears every address count and row budget, so previously refused programs are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_req | input | 1 | Command request |
| cmd_erase | input | 1 | 1 = mass erase, 0 = program |
| cmd_row | input | ROW_W | Row to program |
| cmd_mask | input | 2^COL_W | Bytes of the row to program |
| cmd_data | input | 8·2^COL_W | Byte data, byte i at bits 8i+7:8i |
| cmd_ack | output | 1 | One-cycle answer to a request |
| cmd_err | output | 1 | Command refused (valid with cmd_ack) |
| busy | output | 1 | Operation in progress |
| supply_req | output | 1 | External programming supply request |
| prog_sel | output | 1 | Program select |
| erase_sel | output | 1 | Mass-erase select |
| hv_en | output | 1 | High-voltage enable |
| wr_stb | output | 1 | Write-data strobe |
| arr_addr | output | ROW_W+COL_W | Byte address during a write, else 0 |
| arr_data | output | 8 | Byte data during a write, else 0 |

## Verification
The assertions place no condition on the host inputs. Strobe nesting, setup before high voltage, the maximum write width and the quiet idle state have to hold for any request pattern, including requests made while busy. The stimulus holds a request until the acknowledge cycle and drops it right after. On purpose, it also raises a request with different fields in the middle of a program, to show that the command is latched and the request is ignored. Wear limits are driven into both refusal paths separately, using a reduced row budget and erase time so that each limit is reached within a few commands.

// File: rtl/nvm_seq_pkg.sv
// Shared types and elaboration-time helpers for the flash program/erase sequencer.
// Assumes every interval is given in nanoseconds and the clock in kHz.
package nvm_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SUP_SU,
        ST_SEL_SU,
        ST_HV_SU,
        ST_WRITE,
        ST_GAP,
        ST_ERASE,
        ST_HOLD,
        ST_SUP_HOLD,
        ST_RECOVER
    } seq_state_e;

    // Converts a time in ns to clock cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned khz);
        longint unsigned prod;
        longint unsigned cyc;
        prod = 64'(ns) * 64'(khz);
        cyc  = (prod + 64'd999999) / 64'd1000000;
        if (cyc == 64'd0) cyc = 64'd1;
        return 32'(cyc);
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvm_seq_timer.sv
// Interval down-counter. A load sets the count; the count then falls by one
// each cycle and holds at zero. A state loaded with N-1 therefore lasts N cycles.
module nvm_seq_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/nvm_seq_pick.sv
// Lowest-index set-bit picker for the pending byte mask. Assumes N is at least 2.
module nvm_seq_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign any = |vec;
endmodule

// File: rtl/nvm_seq_wear.sv
// Wear bookkeeping between erases: a 2-bit saturating program count per byte
// address and a used write-time total per row. It judges a candidate program
// command combinationally and records it on commit. An erase commit clears all.
// Assumes the caller commits only commands that were judged legal.
module nvm_seq_wear #(
    parameter int unsigned ROW_W      = 5,
    parameter int unsigned COL_W      = 2,
    parameter int unsigned WR_CYC     = 400,
    parameter int unsigned BUDGET_CYC = 160000,
    parameter int unsigned BUD_W      = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ROW_W-1:0]        chk_row,
    input  logic [(1<<COL_W)-1:0]   chk_mask,
    input  logic                    commit_prog,
    input  logic                    commit_erase,
    output logic                    addr_full,
    output logic                    over_budget
);
    localparam int unsigned ROWS  = 1 << ROW_W;
    localparam int unsigned RB    = 1 << COL_W;
    localparam int unsigned NADDR = ROWS * RB;

    logic [NADDR-1:0] hit_full;
    logic [BUD_W-1:0] used_arr [ROWS];
    logic [BUD_W-1:0] cost;

    // Write-time cost of the candidate: bytes in the mask times the pulse length.
    always_comb begin
        int unsigned n;
        n = 0;
        for (int b = 0; b < int'(RB); b++) n = n + 32'(chk_mask[b]);
        cost = BUD_W'(n * WR_CYC);
    end

    for (genvar a = 0; a < int'(NADDR); a++) begin : g_addr
        logic [1:0] hits;
        // Count programs of this byte address, saturating at two.
        always_ff @(posedge clk) begin
            if (!rst_n)                 hits <= 2'd0;
            else if (commit_erase)      hits <= 2'd0;
            else if (commit_prog && chk_row == ROW_W'(a >> COL_W) &&
                     chk_mask[a % RB] && hits != 2'd2)
                                        hits <= hits + 2'd1;
        end
        assign hit_full[a] = (hits == 2'd2);
    end

    for (genvar r = 0; r < int'(ROWS); r++) begin : g_row
        logic [BUD_W-1:0] used;
        // Accumulate the write time spent on this row.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   used <= '0;
            else if (commit_erase)                        used <= '0;
            else if (commit_prog && chk_row == ROW_W'(r)) used <= used + cost;
        end
        assign used_arr[r] = used;
    end

    // Flag any selected address that is already at its limit.
    always_comb begin
        addr_full = 1'b0;
        for (int b = 0; b < int'(RB); b++) begin
            if (chk_mask[b] && hit_full[{chk_row, COL_W'(b)}]) addr_full = 1'b1;
        end
    end

    assign over_budget = (used_arr[chk_row] + cost) > BUD_W'(BUDGET_CYC);
endmodule

// File: rtl/nvm_pe_sequencer.sv
// Flash program/erase sequencer top. It accepts one command at a time, judges
// program commands against the wear records, and walks the strobes through
// supply setup, select setup, high voltage, writes or erase, hold, supply hold
// and recovery. Each interval comes from the clock-frequency parameter.
// Assumes cmd_* fields are valid whenever cmd_req is high.
module nvm_pe_sequencer
    import nvm_seq_pkg::*;
#(
    parameter int unsigned CLK_KHZ          = 20000,
    parameter int unsigned ROW_W            = 5,
    parameter int unsigned COL_W            = 2,
    parameter int unsigned T_SUPPLY_SU_NS   = 1200,
    parameter int unsigned T_SUPPLY_HOLD_NS = 1200,
    parameter int unsigned T_SEL_HV_NS      = 5000,
    parameter int unsigned T_HV_WR_NS       = 10000,
    parameter int unsigned T_WR_NS          = 20000,
    parameter int unsigned T_PROG_HOLD_NS   = 5000,
    parameter int unsigned T_ERASE_HOLD_NS  = 100000,
    parameter int unsigned T_ERASE_NS       = 500000000,
    parameter int unsigned T_RECOVER_NS     = 1000,
    parameter int unsigned ROW_BUDGET_NS    = 8000000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_req,
    input  logic                      cmd_erase,
    input  logic [ROW_W-1:0]          cmd_row,
    input  logic [(1<<COL_W)-1:0]     cmd_mask,
    input  logic [(8<<COL_W)-1:0]     cmd_data,
    output logic                      cmd_ack,
    output logic                      cmd_err,
    output logic                      busy,
    output logic                      supply_req,
    output logic                      prog_sel,
    output logic                      erase_sel,
    output logic                      hv_en,
    output logic                      wr_stb,
    output logic [ROW_W+COL_W-1:0]    arr_addr,
    output logic [7:0]                arr_data
);
    localparam int unsigned RB         = 1 << COL_W;
    localparam int unsigned C_SUP_SU   = ns_to_cyc(T_SUPPLY_SU_NS, CLK_KHZ);
    localparam int unsigned C_SUP_HOLD = ns_to_cyc(T_SUPPLY_HOLD_NS, CLK_KHZ);
    localparam int unsigned C_SEL_HV   = ns_to_cyc(T_SEL_HV_NS, CLK_KHZ);
    localparam int unsigned C_HV_WR    = ns_to_cyc(T_HV_WR_NS, CLK_KHZ);
    localparam int unsigned C_WR       = ns_to_cyc(T_WR_NS, CLK_KHZ);
    localparam int unsigned C_P_HOLD   = ns_to_cyc(T_PROG_HOLD_NS, CLK_KHZ);
    localparam int unsigned C_E_HOLD   = ns_to_cyc(T_ERASE_HOLD_NS, CLK_KHZ);
    localparam int unsigned C_ERASE    = ns_to_cyc(T_ERASE_NS, CLK_KHZ);
    localparam int unsigned C_RECOVER  = ns_to_cyc(T_RECOVER_NS, CLK_KHZ);
    localparam int unsigned C_BUDGET   = ns_to_cyc(ROW_BUDGET_NS, CLK_KHZ);
    localparam int unsigned C_MAX      = max2(max2(max2(C_SUP_SU, C_SUP_HOLD), max2(C_SEL_HV, C_HV_WR)),
                                              max2(max2(C_WR, C_P_HOLD), max2(max2(C_E_HOLD, C_ERASE), C_RECOVER)));
    localparam int unsigned TW         = $clog2(C_MAX + 1);
    localparam int unsigned BUD_W      = $clog2(C_BUDGET + RB * C_WR + 1);

    seq_state_e               state, nxt;
    logic                     tmr_zero, ld;
    logic [TW-1:0]            ldv;
    logic [ROW_W-1:0]         row_q;
    logic [RB-1:0]            mask_q, rest;
    logic [(8<<COL_W)-1:0]    data_q;
    logic                     erase_q, ack_q, err_q;
    logic [COL_W-1:0]         cur_idx;
    logic                     cur_any;
    logic                     addr_full, over_budget;
    logic                     try_cmd, bad_cmd, accept;

    nvm_seq_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ldv), .zero(tmr_zero)
    );

    nvm_seq_pick #(.N(RB), .IW(COL_W)) u_pick (
        .vec(mask_q), .idx(cur_idx), .any(cur_any)
    );

    nvm_seq_wear #(
        .ROW_W(ROW_W), .COL_W(COL_W), .WR_CYC(C_WR),
        .BUDGET_CYC(C_BUDGET), .BUD_W(BUD_W)
    ) u_wear (
        .clk(clk), .rst_n(rst_n), .chk_row(cmd_row), .chk_mask(cmd_mask),
        .commit_prog(accept && !cmd_erase), .commit_erase(accept && cmd_erase),
        .addr_full(addr_full), .over_budget(over_budget)
    );

    // Command judgement: only in idle, once per request, program checked for wear.
    assign try_cmd = (state == ST_IDLE) && cmd_req && !ack_q;
    assign bad_cmd = !cmd_erase && ((cmd_mask == '0) || addr_full || over_budget);
    assign accept  = try_cmd && !bad_cmd;

    // Bytes still pending after the current one.
    assign rest = mask_q & ~(RB'(1) << cur_idx);

    // Next state and the interval to load on each transition.
    always_comb begin
        nxt = state;
        ld  = 1'b0;
        ldv = '0;
        unique case (state)
            ST_IDLE: if (accept) begin
                nxt = ST_SUP_SU;  ld = 1'b1; ldv = TW'(C_SUP_SU - 1);
            end
            ST_SUP_SU: if (tmr_zero) begin
                nxt = ST_SEL_SU;  ld = 1'b1; ldv = TW'(C_SEL_HV - 1);
            end
            ST_SEL_SU: if (tmr_zero) begin
                ld = 1'b1;
                if (erase_q) begin nxt = ST_ERASE; ldv = TW'(C_ERASE - 1); end
                else         begin nxt = ST_HV_SU; ldv = TW'(C_HV_WR - 1); end
            end
            ST_HV_SU: if (tmr_zero) begin
                nxt = ST_WRITE;   ld = 1'b1; ldv = TW'(C_WR - 1);
            end
            ST_WRITE: if (tmr_zero) begin
                ld = 1'b1;
                if (rest != '0) begin nxt = ST_GAP;  ldv = '0; end
                else            begin nxt = ST_HOLD; ldv = TW'(C_P_HOLD - 1); end
            end
            ST_GAP: if (tmr_zero) begin
                nxt = ST_WRITE;   ld = 1'b1; ldv = TW'(C_WR - 1);
            end
            ST_ERASE: if (tmr_zero) begin
                nxt = ST_HOLD;    ld = 1'b1; ldv = TW'(C_E_HOLD - 1);
            end
            ST_HOLD: if (tmr_zero) begin
                nxt = ST_SUP_HOLD; ld = 1'b1; ldv = TW'(C_SUP_HOLD - 1);
            end
            ST_SUP_HOLD: if (tmr_zero) begin
                nxt = ST_RECOVER; ld = 1'b1; ldv = TW'(C_RECOVER - 1);
            end
            ST_RECOVER: if (tmr_zero) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State, latched command and handshake registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            row_q   <= '0;
            mask_q  <= '0;
            data_q  <= '0;
            erase_q <= 1'b0;
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state <= nxt;
            ack_q <= try_cmd;
            err_q <= try_cmd && bad_cmd;
            if (accept) begin
                row_q   <= cmd_row;
                mask_q  <= cmd_mask;
                data_q  <= cmd_data;
                erase_q <= cmd_erase;
            end else if (state == ST_WRITE && tmr_zero) begin
                mask_q  <= rest;
            end
        end
    end

    // Strobe decode from the registered state.
    always_comb begin
        busy       = (state != ST_IDLE);
        supply_req = state inside {ST_SUP_SU, ST_SEL_SU, ST_HV_SU, ST_WRITE, ST_GAP,
                                   ST_ERASE, ST_HOLD, ST_SUP_HOLD};
        prog_sel   = !erase_q && (state inside {ST_SEL_SU, ST_HV_SU, ST_WRITE, ST_GAP, ST_HOLD});
        erase_sel  = erase_q && (state inside {ST_SEL_SU, ST_ERASE, ST_HOLD});
        hv_en      = state inside {ST_HV_SU, ST_WRITE, ST_GAP, ST_ERASE};
        wr_stb     = (state == ST_WRITE) && cur_any;
        arr_addr   = wr_stb ? {row_q, cur_idx} : '0;
        arr_data   = wr_stb ? data_q[{cur_idx, 3'b000} +: 8] : 8'h00;
    end

    assign cmd_ack = ack_q;
    assign cmd_err = err_q;
endmodule

// File: rtl/nvm_seq_chk.sv
// Timing checker for the sequencer strobes, bound into the top module.
// Assumes only a running clock and the synchronous active-low reset.
module nvm_seq_chk
    import nvm_seq_pkg::*;
#(
    parameter int unsigned CLK_KHZ     = 20000,
    parameter int unsigned T_SEL_HV_NS = 5000,
    parameter int unsigned T_WR_MAX_NS = 40000
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_ack,
    input logic cmd_err,
    input logic busy,
    input logic supply_req,
    input logic prog_sel,
    input logic erase_sel,
    input logic hv_en,
    input logic wr_stb
);
    localparam int unsigned SEL_HV_CYC = ns_to_cyc(T_SEL_HV_NS, CLK_KHZ);
    localparam int unsigned WR_MAX_CYC = ns_to_cyc(T_WR_MAX_NS, CLK_KHZ);

    logic [31:0] sel_run, wr_run;

    // Count the consecutive cycles each strobe has already been high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_run <= '0;
            wr_run  <= '0;
        end else begin
            sel_run <= (prog_sel || erase_sel) ? ((&sel_run) ? sel_run : sel_run + 1) : '0;
            wr_run  <= wr_stb ? ((&wr_run) ? wr_run : wr_run + 1) : '0;
        end
    end

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_sel && erase_sel)); // R3
    AST_SEL_HAS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_sel || erase_sel) |-> supply_req); // R2
    AST_HV_HAS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        hv_en |-> (prog_sel || erase_sel)); // R3
    AST_HV_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_en) |-> (sel_run >= SEL_HV_CYC)); // R3
    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (hv_en && prog_sel)); // R4
    AST_WR_MAX_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_run < WR_MAX_CYC)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(supply_req || prog_sel || erase_sel || hv_en || wr_stb)); // R6
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |=> !cmd_ack); // R7
    AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> cmd_ack); // R7
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ack && cmd_err) |-> !busy); // R10
endmodule

bind nvm_pe_sequencer nvm_seq_chk #(
    .CLK_KHZ(CLK_KHZ), .T_SEL_HV_NS(T_SEL_HV_NS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ack(cmd_ack), .cmd_err(cmd_err), .busy(busy),
    .supply_req(supply_req), .prog_sel(prog_sel), .erase_sel(erase_sel),
    .hv_en(hv_en), .wr_stb(wr_stb)
);

// File: tb/sim_nvm_pe_sequencer.sv
`timescale 1ns/1ps
module sim_nvm_pe_sequencer;
    localparam int ROW_W = 3;
    localparam int COL_W = 2;
    localparam int KHZ   = 2000;

    function automatic int cyc(longint ns);
        longint c;
        c = (ns * KHZ + 999999) / 1000000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    localparam int SU    = cyc(1200);
    localparam int SHOLD = cyc(1200);
    localparam int SELHV = cyc(5000);
    localparam int HVWR  = cyc(10000);
    localparam int WR    = cyc(20000);
    localparam int PHOLD = cyc(5000);
    localparam int EHOLD = cyc(100000);
    localparam int ERASE = cyc(1000000);
    localparam int RECOV = cyc(1000);
    localparam int BUD   = cyc(120000);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, op_i = 1'b0;
    logic [ROW_W-1:0] row_i = '0;
    logic [3:0] mask_i = '0;
    logic [31:0] data_i = '0;
    logic ack, err, busy, sup, ps, es, hv, wr;
    logic [ROW_W+COL_W-1:0] addr;
    logic [7:0] data;

    always #10 clk = ~clk;

    nvm_pe_sequencer #(
        .CLK_KHZ(KHZ), .ROW_W(ROW_W), .COL_W(COL_W),
        .T_ERASE_NS(1000000), .ROW_BUDGET_NS(120000)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_req(req), .cmd_erase(op_i), .cmd_row(row_i),
        .cmd_mask(mask_i), .cmd_data(data_i), .cmd_ack(ack), .cmd_err(err), .busy(busy),
        .supply_req(sup), .prog_sel(ps), .erase_sel(es), .hv_en(hv), .wr_stb(wr),
        .arr_addr(addr), .arr_data(data)
    );

    typedef logic [18:0] exp_t; // {busy,sup,ps,es,hv,wr} addr[12:8] data[7:0]
    exp_t q[$];
    int hits[32];
    int used[8];
    int checks = 0, errors = 0, wd = 0;
    logic exp_ack = 1'b0, exp_err = 1'b0;
    string ack_tag = "R7";

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            checks++; errors++;
            $display("FAIL R6 watchdog: busy act=%b exp=0", busy);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic push(int n, logic [5:0] f, logic [4:0] a, logic [7:0] d);
        for (int i = 0; i < n; i++) q.push_back({f, a, d});
    endtask

    task automatic step(string tag);
        exp_t e;
        logic [5:0] act;
        @(negedge clk);
        e = '0;
        if (q.size() > 0) e = q.pop_front();
        act = {busy, sup, ps, es, hv, wr};
        checks++;
        if (act !== e[18:13] || (e[13] && (addr !== e[12:8] || data !== e[7:0]))) begin
            errors++;
            $display("FAIL %s: strobes act=%b exp=%b addr act=%h exp=%h data act=%h exp=%h",
                     tag, act, e[18:13], addr, e[12:8], data, e[7:0]);
        end
        checks++;
        if (ack !== exp_ack || err !== exp_err) begin
            errors++;
            $display("FAIL %s: ack/err act=%b%b exp=%b%b", ack_tag, ack, err, exp_ack, exp_err);
        end
        exp_ack = 1'b0;
        exp_err = 1'b0;
    endtask

    task automatic run_cmd(bit op, int row, bit [3:0] mask, bit [31:0] dat,
                           string seq_tag, string atag, int poke_at);
        int n, k;
        bit bad;
        int idx[$];
        n = $countones(mask);
        bad = 1'b0;
        if (!op) begin
            if (mask == 0) bad = 1'b1;
            for (int i = 0; i < 4; i++) if (mask[i] && hits[row*4+i] >= 2) bad = 1'b1;
            if (used[row] + n * WR > BUD) bad = 1'b1;
        end
        if (!bad) begin
            if (op) begin
                push(SU, 6'b110000, 0, 0);
                push(SELHV, 6'b110100, 0, 0);
                push(ERASE, 6'b110110, 0, 0);
                push(EHOLD, 6'b110100, 0, 0);
                foreach (hits[i]) hits[i] = 0;
                foreach (used[i]) used[i] = 0;
            end else begin
                push(SU, 6'b110000, 0, 0);
                push(SELHV, 6'b111000, 0, 0);
                push(HVWR, 6'b111010, 0, 0);
                for (int i = 0; i < 4; i++) if (mask[i]) idx.push_back(i);
                foreach (idx[j]) begin
                    push(WR, 6'b111011, 5'(row * 4 + idx[j]), dat[8*idx[j] +: 8]);
                    if (j < idx.size() - 1) push(1, 6'b111010, 0, 0);
                    hits[row*4+idx[j]]++;
                end
                used[row] += n * WR;
                push(PHOLD, 6'b111000, 0, 0);
            end
            push(SHOLD, 6'b110000, 0, 0);
            push(RECOV, 6'b100000, 0, 0);
        end
        req = 1'b1; op_i = op; row_i = 3'(row); mask_i = mask; data_i = dat;
        exp_ack = 1'b1; exp_err = bad; ack_tag = atag;
        step(seq_tag);
        req = 1'b0;
        ack_tag = "R6";
        k = 0;
        while (q.size() > 0) begin
            if (k == poke_at) begin req = 1'b1; op_i = 1'b1; row_i = 3'd5; mask_i = 4'hF; data_i = 32'hDEADBEEF; end
            if (k == poke_at + 5) req = 1'b0;
            step(seq_tag);
            k++;
        end
        step(seq_tag);
    endtask

    initial begin
        foreach (hits[i]) hits[i] = 0;
        foreach (used[i]) used[i] = 0;
        repeat (3) @(negedge clk);
        checks++;
        if ({ack, err, busy, sup, ps, es, hv, wr} !== 8'h00) begin
            errors++;
            $display("FAIL R1: outputs in reset act=%b exp=00000000", {ack, err, busy, sup, ps, es, hv, wr});
        end
        rst_n = 1'b1;
        step("R1");
        step("R1");
        // R2 R3 R4 R6: full-row program with a request poked in while busy
        run_cmd(1'b0, 0, 4'b1111, 32'h44332211, "R4", "R7", 30);
        // R4: second pass on two bytes, row budget reaches exactly its limit
        run_cmd(1'b0, 0, 4'b0011, 32'hA5A5_C3B2, "R3", "R7", -1);
        // R9: one more byte would exceed the row budget
        run_cmd(1'b0, 0, 4'b0100, 32'h00FF0000, "R10", "R9", -1);
        // R8: same address twice accepted, third refused
        run_cmd(1'b0, 1, 4'b0001, 32'h0000005A, "R4", "R7", -1);
        run_cmd(1'b0, 1, 4'b0001, 32'h00000066, "R4", "R7", -1);
        run_cmd(1'b0, 1, 4'b0001, 32'h00000077, "R10", "R8", -1);
        // R10: row still usable after the refusal
        run_cmd(1'b0, 1, 4'b0010, 32'h00009900, "R4", "R10", -1);
        // R11: empty mask refused
        run_cmd(1'b0, 2, 4'b0000, 32'h12345678, "R10", "R11", -1);
        // R5: mass erase
        run_cmd(1'b1, 0, 4'b0000, 32'h0, "R5", "R7", -1);
        // R12: previously refused programs accepted again
        run_cmd(1'b0, 1, 4'b0001, 32'h00000011, "R12", "R12", -1);
        run_cmd(1'b0, 0, 4'b0100, 32'h00EE0000, "R12", "R12", -1);
        // R4: non-adjacent bytes on the last row
        run_cmd(1'b0, 7, 4'b1010, 32'h8070_6050, "R4", "R7", -1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule